// File: doc/BRIEF.md
# SPI Command-Framed Register Slave

This block is a serial slave that lets a host microcontroller reach on-chip storage over a four-wire SPI link. Each transaction sits inside one chip-select low period. The first byte is a command, the second is a start address, and any number of data bytes follow back to back. The command's top bit picks the direction. Its low three bits pick an operation mode, which names the internal space the transfer targets: flat configuration registers, vocoder voice data, a control packet buffer, or any other space wired to the bus.

Toward the chip the slave drives a simple registered parallel bus. A one-cycle write strobe carries mode, address and data. A one-cycle read strobe carries mode and address, and the addressed location returns its byte one clock later. The address steps by one after every data byte. The packet and voice modes cap the payload per transaction: surplus written bytes are dropped, and surplus read bytes come back as zero. The serial pins are synchronised into the system clock, so the serial clock must run well below the system clock.

Top module: `spi_cmd_regslave`

## Requirements
- R1: While `rst` is high and on the cycle after it, `miso`, `bus_wr` and `bus_rd` are all low.
- R2: Command bit 7 set selects a read and clear selects a write. Bits 2..0 select the mode shown on `bus_mode`. Bits 6..3 have no effect.
- R3: In a write, data byte k (counting from 0) produces exactly one `bus_wr` pulse with `bus_addr` equal to the start address plus k, `bus_wdata` equal to the byte, and the command's mode.
- R4: In a read, data byte k shifts out, MSB first, the content of the start address plus k. `miso` changes only after falling `sclk` edges and is stable at each rising edge.
- R5: A read fetch is a one-cycle `bus_rd` pulse. `bus_rdata` is taken on the following cycle, and `bus_addr` holds during that cycle.
- R6: In mode 101 (control packet, command 0x05), a write stores at most PKT_WR_MAX (default 19) bytes per transaction. Later bytes cause no `bus_wr`.
- R7: In mode 101 read (command 0x85), at most PKT_RD_MAX (default 9) bytes are fetched. Later bytes read as 0x00 and cause no `bus_rd`.
- R8: In mode 011 (voice data), both directions are limited to VOICE_MAX (default 16) bytes, with the same drop and zero rules.
- R9: All other modes, including 000 (configuration registers), have no length limit. The address wraps from 0xFF to 0x00.
- R10: Raising `cs_n` discards any partial byte and returns the slave to expecting a command byte. Within SYNC_STAGES+2 clocks, `miso` is driven low and stays low while `cs_n` is high.
- R11: Bytes received on `mosi` during a read transaction cause no write.
- R12: `bus_wr` and `bus_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idle low |
| cs_n | input | 1 | Active-low chip select framing a transaction |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, low when deselected |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_mode | output | 3 | Operation mode of the current access |
| bus_addr | output | 8 | Location addressed by the strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |

## Verification
A bit counter that has slipped misaligns every later byte of the transaction. The next bus write then carries a wrong address or data value, and a read shifts a rotated byte onto `miso` on the next byte period. A wrong window index shows as an extra or missing strobe at the first byte past a length limit, or as a nonzero byte where 0x00 is due. A framing state that survives chip select shows on the very next transaction, as a write to the wrong place or with the wrong mode.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] OPM_REG   = 3'b000;
  localparam logic [2:0] OPM_VOICE = 3'b011;
  localparam logic [2:0] OPM_PKT   = 3'b101;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // modes that carry a per-transaction payload cap
  function automatic logic mode_capped(input logic [2:0] m);
    return (m == OPM_PKT) || (m == OPM_VOICE);
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel,
  output logic mosi_q
);
  localparam int SCK_L = STAGES + 1;

  logic [SCK_L-1:0]  sck_p;
  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] mo_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      cs_p  <= '1;
      mo_p  <= '0;
    end else begin
      sck_p <= {sck_p[SCK_L-2:0], sclk_i};
      cs_p  <= {cs_p[STAGES-2:0], cs_n_i};
      mo_p  <= {mo_p[STAGES-2:0], mosi_i};
    end
  end

  // mosi stage aligned with the sclk stage used for edge detection
  assign sclk_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sclk_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
  assign sel       = ~cs_p[STAGES-1];
  assign mosi_q    = mo_p[STAGES-1];
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rise,
  input  logic              fall,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_done,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      rx_done <= 1'b0;
      tx_sh   <= '0;
      miso    <= 1'b0;
    end else if (!sel) begin
      bit_cnt <= '0;
      rx_done <= 1'b0;
      tx_sh   <= '0;
      miso    <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (rise) begin
        rx_sh   <= {rx_sh[BYTE_W-3:0], mosi};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          rx_byte <= {rx_sh, mosi};
          rx_done <= 1'b1;
        end
      end
      if (fall) begin
        if (bit_cnt == '0) begin
          miso  <= tx_byte[BYTE_W-1];
          tx_sh <= {tx_byte[BYTE_W-2:0], 1'b0};
        end else begin
          miso  <= tx_sh[BYTE_W-1];
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_txn_seq.sv
module spi_txn_seq
  import spi_cmd_pkg::*;
#(
  parameter int PKT_WR_MAX = 19,
  parameter int PKT_RD_MAX = 9,
  parameter int VOICE_MAX  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [2:0]        bus_mode,
  output logic [BYTE_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] tx_byte
);
  localparam int IDX_W = 8;
  localparam logic [IDX_W-1:0] IDX_TOP = '1;
  localparam logic [IDX_W-1:0] LIM_PW  = IDX_W'(PKT_WR_MAX);
  localparam logic [IDX_W-1:0] LIM_PR  = IDX_W'(PKT_RD_MAX);
  localparam logic [IDX_W-1:0] LIM_V   = IDX_W'(VOICE_MAX);

  phase_t            phase;
  logic              is_rd;
  logic [2:0]        mode;
  logic [BYTE_W-1:0] addr;
  logic [IDX_W-1:0]  idx;
  logic              rd_pend;

  logic [IDX_W-1:0]  idx_nxt;
  logic [IDX_W-1:0]  lim;
  logic              win_now;
  logic              win_nxt;
  logic [BYTE_W-1:0] addr_nxt;

  always_comb begin
    idx_nxt  = (idx == IDX_TOP) ? idx : idx + 1'b1;
    addr_nxt = addr + 1'b1;
    if (mode == OPM_PKT) lim = is_rd ? LIM_PR : LIM_PW;
    else                 lim = LIM_V;
    win_now = !mode_capped(mode) || (idx < lim);
    win_nxt = !mode_capped(mode) || (idx_nxt < lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      is_rd     <= 1'b0;
      mode      <= OPM_REG;
      addr      <= '0;
      idx       <= '0;
      rd_pend   <= 1'b0;
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_mode  <= OPM_REG;
      bus_addr  <= '0;
      bus_wdata <= '0;
      tx_byte   <= '0;
    end else if (!sel) begin
      phase   <= PH_CMD;
      idx     <= '0;
      rd_pend <= 1'b0;
      bus_wr  <= 1'b0;
      bus_rd  <= 1'b0;
      tx_byte <= '0;
    end else begin
      bus_wr  <= 1'b0;
      bus_rd  <= 1'b0;
      rd_pend <= bus_rd;
      if (rd_pend) tx_byte <= bus_rdata;
      if (rx_done) begin
        unique case (phase)
          PH_CMD: begin
            is_rd <= rx_byte[BYTE_W-1];
            mode  <= rx_byte[2:0];
            idx   <= '0;
            phase <= PH_ADDR;
          end
          PH_ADDR: begin
            addr  <= rx_byte;
            phase <= PH_DATA;
            if (is_rd) begin
              if (win_now) begin
                bus_rd   <= 1'b1;
                bus_addr <= rx_byte;
                bus_mode <= mode;
              end else begin
                tx_byte <= '0;
              end
            end
          end
          PH_DATA: begin
            addr <= addr_nxt;
            idx  <= idx_nxt;
            if (is_rd) begin
              if (win_nxt) begin
                bus_rd   <= 1'b1;
                bus_addr <= addr_nxt;
                bus_mode <= mode;
              end else begin
                tx_byte <= '0;
              end
            end else if (win_now) begin
              bus_wr    <= 1'b1;
              bus_addr  <= addr;
              bus_mode  <= mode;
              bus_wdata <= rx_byte;
            end
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_cmd_regslave.sv
module spi_cmd_regslave
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PKT_WR_MAX  = 19,
  parameter int PKT_RD_MAX  = 9,
  parameter int VOICE_MAX   = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        bus_wr,
  output logic        bus_rd,
  output logic [2:0]  bus_mode,
  output logic [7:0]  bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata
);
  logic              s_rise;
  logic              s_fall;
  logic              s_sel;
  logic              s_mosi;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_done;
  logic [BYTE_W-1:0] tx_byte;

  spi_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .sclk_i    (sclk),
    .cs_n_i    (cs_n),
    .mosi_i    (mosi),
    .sclk_rise (s_rise),
    .sclk_fall (s_fall),
    .sel       (s_sel),
    .mosi_q    (s_mosi)
  );

  spi_byte_engine byte_i (
    .clk     (clk),
    .rst     (rst),
    .sel     (s_sel),
    .rise    (s_rise),
    .fall    (s_fall),
    .mosi    (s_mosi),
    .tx_byte (tx_byte),
    .rx_byte (rx_byte),
    .rx_done (rx_done),
    .miso    (miso)
  );

  spi_txn_seq #(
    .PKT_WR_MAX (PKT_WR_MAX),
    .PKT_RD_MAX (PKT_RD_MAX),
    .VOICE_MAX  (VOICE_MAX)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .sel       (s_sel),
    .rx_done   (rx_done),
    .rx_byte   (rx_byte),
    .bus_rdata (bus_rdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_mode  (bus_mode),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_byte   (tx_byte)
  );
endmodule

// File: rtl/spi_cmd_regslave_chk.sv
module spi_cmd_regslave_chk
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PKT_WR_MAX  = 19,
  parameter int PKT_RD_MAX  = 9,
  parameter int VOICE_MAX   = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       miso,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [2:0] bus_mode,
  input logic [7:0] bus_addr
);
  logic [3:0] hi_cnt;
  logic [7:0] pw_cnt, pr_cnt, v_cnt;
  logic       quiet;

  assign quiet = hi_cnt >= 4'(SYNC_STAGES + 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      pw_cnt <= '0;
      pr_cnt <= '0;
      v_cnt  <= '0;
    end else begin
      if (!cs_n)              hi_cnt <= '0;
      else if (hi_cnt != 4'hF) hi_cnt <= hi_cnt + 1'b1;
      if (quiet) begin
        pw_cnt <= '0;
        pr_cnt <= '0;
        v_cnt  <= '0;
      end else begin
        if (bus_wr && bus_mode == OPM_PKT && pw_cnt != 8'hFF) pw_cnt <= pw_cnt + 1'b1;
        if (bus_rd && bus_mode == OPM_PKT && pr_cnt != 8'hFF) pr_cnt <= pr_cnt + 1'b1;
        if ((bus_wr || bus_rd) && bus_mode == OPM_VOICE && v_cnt != 8'hFF) v_cnt <= v_cnt + 1'b1;
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!bus_wr && !bus_rd && !miso));
  // R10
  idle_miso_chk: assert property (@(posedge clk) disable iff (rst) quiet |-> !miso);
  // R5
  rd_addr_hold_chk: assert property (@(posedge clk) disable iff (rst) bus_rd |=> ($stable(bus_addr) && !bus_rd));
  // R6
  pkt_wr_cap_chk: assert property (@(posedge clk) disable iff (rst) pw_cnt <= 8'(PKT_WR_MAX));
  // R7
  pkt_rd_cap_chk: assert property (@(posedge clk) disable iff (rst) pr_cnt <= 8'(PKT_RD_MAX));
  // R8
  voice_cap_chk: assert property (@(posedge clk) disable iff (rst) v_cnt <= 8'(VOICE_MAX));
  // R12
  excl_strobe_chk: assert property (@(posedge clk) disable iff (rst) !(bus_wr && bus_rd));
endmodule

bind spi_cmd_regslave spi_cmd_regslave_chk #(
  .SYNC_STAGES (SYNC_STAGES),
  .PKT_WR_MAX  (PKT_WR_MAX),
  .PKT_RD_MAX  (PKT_RD_MAX),
  .VOICE_MAX   (VOICE_MAX)
) chk_i (.*);

// File: tb/spi_cmd_regslave_tb_top.sv
module spi_cmd_regslave_tb_top;
  localparam int HP  = 8;
  localparam int NOL = 1000;

  logic clk = 1'b0;
  logic rst, sclk, cs_n, mosi, miso, bus_wr, bus_rd;
  logic [2:0] bus_mode;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  spi_cmd_regslave dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_mode(bus_mode), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] pattern(input logic [2:0] m, input logic [7:0] a);
    return a ^ {m, 5'b0} ^ 8'hA5;
  endfunction

  // storage responder: one-cycle read latency
  logic       wflag [8][256];
  logic [7:0] wval  [8][256];
  always @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < 8; m++) for (int a = 0; a < 256; a++) wflag[m][a] <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      if (bus_wr) begin
        wflag[bus_mode][bus_addr] <= 1'b1;
        wval[bus_mode][bus_addr]  <= bus_wdata;
      end
      if (bus_rd)
        bus_rdata <= wflag[bus_mode][bus_addr] ? wval[bus_mode][bus_addr] : pattern(bus_mode, bus_addr);
    end
  end

  typedef struct packed { logic [2:0] m; logic [7:0] a; logic [7:0] d; } wr_item_t;
  wr_item_t exp_q[$];

  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
  int wr_total = 0, rd_total = 0;
  bit done = 1'b0;
  logic [7:0] shadow [8][256];

  // monitor: compares bus writes with the scoreboard queue
  always @(negedge clk) begin
    if (!rst && (bus_wr || bus_rd)) begin
      mon_chk++;
      if (bus_wr && bus_rd) begin
        mon_fail++;
        $display("FAIL R12 act=both strobes exp=one strobe");
      end
    end
    if (!rst && bus_rd) rd_total++;
    if (!rst && bus_wr) begin
      wr_total++;
      if (exp_q.size() == 0) begin
        mon_fail++;
        $display("FAIL R3/R6/R8/R11 unexpected write act=%h:%h:%h exp=none", bus_mode, bus_addr, bus_wdata);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        if (e !== {bus_mode, bus_addr, bus_wdata}) begin
          mon_fail++;
          $display("FAIL R3 write act=%h:%h:%h exp=%h:%h:%h", bus_mode, bus_addr, bus_wdata, e.m, e.a, e.d);
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk) cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HP) @(negedge clk);
  endtask

  task automatic wr_txn(input logic [7:0] cmd, input logic [7:0] addr, input int n,
                        input int lim, input logic [7:0] seed, input string req);
    logic [7:0] rx, d, a;
    logic [2:0] m;
    m = cmd[2:0];
    cs_lo();
    bits(cmd, 8, rx);
    bits(addr, 8, rx);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 7);
      a = addr + 8'(k);
      if (k < lim) begin
        exp_q.push_back({m, a, d});
        shadow[m][a] = d;
      end
      bits(d, 8, rx);
    end
    cs_hi();
    chk({req, " pending writes"}, exp_q.size(), 0);
  endtask

  task automatic rd_txn(input logic [7:0] cmd, input logic [7:0] addr, input int n,
                        input int lim, input string req);
    logic [7:0] rx, e;
    logic [2:0] m;
    m = cmd[2:0];
    cs_lo();
    bits(cmd, 8, rx);
    bits(addr, 8, rx);
    for (int k = 0; k < n; k++) begin
      bits(8'hC3, 8, rx);
      e = (k < lim) ? shadow[m][addr + 8'(k)] : 8'h00;
      chk(req, rx, e);
    end
    cs_hi();
  endtask

  initial begin
    logic [7:0] rx;
    int snap;
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    for (int m = 0; m < 8; m++) for (int a = 0; a < 256; a++) shadow[m][a] = pattern(3'(m), 8'(a));
    repeat (10) @(negedge clk);
    chk("R1 miso", miso, 0);
    chk("R1 bus_wr", bus_wr, 0);
    chk("R1 bus_rd", bus_rd, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R3 plain register write, then R4/R5 readback incl. untouched neighbour
    wr_txn(8'h00, 8'h10, 5, NOL, 8'h31, "R3");
    rd_txn(8'h80, 8'h10, 6, NOL, "R4 R5 readback");

    // R2 reserved bits ignored, mode routing
    wr_txn(8'h78, 8'h30, 3, NOL, 8'h90, "R2");
    rd_txn(8'hF8, 8'h30, 3, NOL, "R2 reserved read");
    rd_txn(8'h82, 8'h10, 2, NOL, "R2 mode 010 space");

    // R6 / R7 control packet
    wr_txn(8'h05, 8'h00, 22, 19, 8'h11, "R6");
    snap = rd_total;
    rd_txn(8'h85, 8'h00, 12, 9, "R7");
    chk("R7 fetch count", rd_total - snap, 9);

    // R8 voice
    wr_txn(8'h03, 8'h20, 18, 16, 8'h4C, "R8 write");
    rd_txn(8'h83, 8'h20, 18, 16, "R8 read");

    // R9 wrap in unlimited mode
    wr_txn(8'h00, 8'hFE, 4, NOL, 8'hE0, "R9");
    rd_txn(8'h80, 8'hFE, 4, NOL, "R9 read");

    // R11 mosi during read writes nothing
    snap = wr_total;
    rd_txn(8'h80, 8'h40, 4, NOL, "R11 read");
    chk("R11 writes during read", wr_total - snap, 0);

    // R10 abort mid-data and mid-command
    cs_lo();
    bits(8'h00, 8, rx);
    bits(8'h50, 8, rx);
    bits(8'hAA, 4, rx);
    cs_hi();
    chk("R10 miso idle", miso, 0);
    cs_lo();
    bits(8'h80, 3, rx);
    cs_hi();
    wr_txn(8'h00, 8'h60, 1, NOL, 8'h77, "R10 fresh frame");
    rd_txn(8'h80, 8'h50, 1, NOL, "R10 no partial write");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk + mon_chk, n_fail + mon_fail);
      $finish;
    end
  end
endmodule